// File: doc/BRIEF.md
# USB Device Interrupt Status and Control Unit

This block keeps the device-level interrupt state of a USB function controller. Seven event sources in the USB engine raise one-cycle pulses: DMA over/underrun, bus error, wakeup, suspend, bus reset, start of frame and missed (expected) start of frame. The block latches each pulse into a sticky flag. Software clears a flag by writing 0 to its bit, and a 1 in the written word leaves that flag as it is. This lets firmware acknowledge exactly the events it has handled without a read-modify-write race.

Bit 15 of the status word is a live summary of the per-endpoint transfer-complete flags, which the endpoint registers own. The low five bits name the lowest-numbered endpoint with a completed transfer and tell whether that completion is a reception. A companion control word holds one enable bit per status source, in the same bit positions, plus five power and reset control bits. A single interrupt line is high while any enabled source is pending.

Top module: `usb_irq_unit`

## Requirements
- R1: After reset the latched event flags are all 0 and the control word reads 0x0003 (force-reset bit 0 and power-down bit 1 set, everything else 0).
- R2: A pulse on `evt_pulse[k]` sets status bit 8+k at the next rising clock edge. Index 6..0 maps to DMA overrun (14), error (13), wakeup (12), suspend (11), bus reset (10), start of frame (9), missed start of frame (8).
- R3: A status write (`wr_en`=1, `wr_sel`=0) clears every event flag whose bit in `wr_data[14:8]` is 0 and leaves flags written with 1 unchanged. Without a status write, no flag ever clears.
- R4: When a pulse arrives in the same cycle as a write clearing that flag, the flag is set after the edge.
- R5: Status bit 15 reads 1 in any cycle in which some endpoint's receive-done or transmit-done input is high, and 0 otherwise. Writes do not change it.
- R6: Status bits 3:0 give the lowest endpoint index with a done input high. Bit 4 is 1 when that endpoint's receive-done is high. Both fields read 0 when no endpoint is pending, and writes do not change them.
- R7: A control write (`wr_en`=1, `wr_sel`=1) stores `wr_data[15:8]` as enable masks and `wr_data[4:0]` as the resume, force-suspend, low-power, power-down and force-reset bits (4 down to 0). Control bits 7:5 and status bits 7:5 always read 0.
- R8: `irq` is high exactly when some status bit in 15:8 and the control bit in the same position are both 1.
- R9: A status write leaves the control word unchanged, and a control write leaves the event flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status word, 1 control word |
| wr_data | input | 16 | Write data |
| evt_pulse | input | 7 | Event pulses, index 6 = DMA overrun down to 0 = missed start of frame |
| ep_rx_done | input | NEP | Per-endpoint reception-complete flags |
| ep_tx_done | input | NEP | Per-endpoint transmission-complete flags |
| stat_rd | output | 16 | Status word |
| ctrl_rd | output | 16 | Control word |
| irq | output | 1 | Interrupt request |

## Verification
Random traffic sends sparse event pulses and endpoint flags together with status and control writes that carry random data. This tells the write-0-clears rule apart from a write-1-clears rule, and it tells apart flags that hold from flags that drift. Directed cases place the completed endpoint only at the top index, set receive and transmit together on one endpoint with a higher endpoint also pending, and clear a flag in the same cycle as its pulse. These expose a priority encoder that picks the wrong end, a direction bit taken from the wrong endpoint, and a clear that overrides a set. The mask cases keep one source pending while its enable toggles, which separates masked from unmasked interrupt logic.

// File: rtl/usb_irq_unit.sv
module usb_irq_unit #(
  parameter int NEP = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [15:0]    wr_data,
  input  logic [6:0]     evt_pulse,
  input  logic [NEP-1:0] ep_rx_done,
  input  logic [NEP-1:0] ep_tx_done,
  output logic [15:0]    stat_rd,
  output logic [15:0]    ctrl_rd,
  output logic           irq
);
  localparam int IDW = 4;
  localparam logic [12:0] CTRL_RST = 13'h0003;

  logic [6:0]     flags;
  logic [12:0]    ctrl;
  logic [NEP-1:0] ep_any;
  logic [IDW-1:0] ep_id;
  logic           ep_dir;

  assign ep_any = ep_rx_done | ep_tx_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      ctrl  <= CTRL_RST;
    end else begin
      if (wr_en && !wr_sel) flags <= (flags & wr_data[14:8]) | evt_pulse;
      else                  flags <= flags | evt_pulse;
      if (wr_en && wr_sel)  ctrl  <= {wr_data[15:8], wr_data[4:0]};
    end
  end

  always_comb begin
    ep_id  = '0;
    ep_dir = 1'b0;
    for (int i = NEP - 1; i >= 0; i--) begin
      if (ep_any[i]) begin
        ep_id  = IDW'(i);
        ep_dir = ep_rx_done[i];
      end
    end
  end

  assign stat_rd = {|ep_any, flags, 3'b000, ep_dir, ep_id};
  assign ctrl_rd = {ctrl[12:5], 3'b000, ctrl[4:0]};
  assign irq     = |(stat_rd[15:8] & ctrl_rd[15:8]);
endmodule

module usb_irq_unit_chk #(
  parameter int NEP = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           wr_sel,
  input logic [15:0]    wr_data,
  input logic [6:0]     evt_pulse,
  input logic [NEP-1:0] ep_rx_done,
  input logic [NEP-1:0] ep_tx_done,
  input logic [15:0]    stat_rd,
  input logic [15:0]    ctrl_rd,
  input logic           irq
);
  // R1
  reset_value_chk: assert property (@(posedge clk)
    !rst_n |=> (ctrl_rd == 16'h0003 && stat_rd[14:8] == 7'h00));

  // R2
  pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != 7'h00) |=> ((stat_rd[14:8] & $past(evt_pulse)) == $past(evt_pulse)));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=> ((~stat_rd[14:8] & $past(stat_rd[14:8])) == 7'h00));

  // R6
  id_points_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[15] |-> (ep_rx_done[stat_rd[3:0]] || ep_tx_done[stat_rd[3:0]]));

  // R6
  idle_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd[15] |-> (stat_rd[4:0] == 5'd0));

  // R7
  gap_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[7:5] == 3'd0 && stat_rd[7:5] == 3'd0));

  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_rd[15:8] != 8'h00 && stat_rd[15:8] != 8'h00));

  // R9
  ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(ctrl_rd));
endmodule

bind usb_irq_unit usb_irq_unit_chk #(.NEP(NEP)) u_chk (.*);

// File: tb/usb_irq_unit_tb.sv
module usb_irq_unit_tb;
  localparam int NEP = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic           wr_sel = 1'b0;
  logic [15:0]    wr_data = '0;
  logic [6:0]     evt_pulse = '0;
  logic [NEP-1:0] ep_rx_done = '0;
  logic [NEP-1:0] ep_tx_done = '0;
  logic [15:0]    stat_rd, ctrl_rd;
  logic           irq;

  int errors = 0;
  int checks = 0;
  logic [6:0]  mflags = '0;
  logic [15:0] mctrl = 16'h0003;

  always #2.5 clk = ~clk;

  usb_irq_unit #(.NEP(NEP)) u_dut (.*);

  function automatic logic [15:0] exp_stat(input logic [6:0] f,
      input logic [NEP-1:0] rx, input logic [NEP-1:0] tx);
    logic [4:0] low = 5'd0;
    for (int i = NEP - 1; i >= 0; i--)
      if (rx[i] || tx[i]) low = {rx[i], 4'(i)};
    return {|(rx | tx), f, 3'b000, low};
  endfunction

  function automatic logic exp_irq(input logic [15:0] s, input logic [15:0] c);
    return |(s[15:8] & c[15:8]);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [15:0] es = exp_stat(mflags, ep_rx_done, ep_tx_done);
    chk({tag, " stat"}, stat_rd, es);
    chk({tag, " ctrl"}, ctrl_rd, mctrl);
    chk({tag, " R8 irq"}, {15'd0, irq}, {15'd0, exp_irq(es, mctrl)});
  endtask

  // drive after negedge, check combinational view, then take the edge
  task automatic cyc(input logic we, input logic sel, input logic [15:0] d,
      input logic [6:0] ev, input logic [NEP-1:0] rx, input logic [NEP-1:0] tx,
      input string tag);
    wr_en = we; wr_sel = sel; wr_data = d; evt_pulse = ev;
    ep_rx_done = rx; ep_tx_done = tx;
    #1;
    check_all(tag);
    @(posedge clk);
    if (we && !sel) mflags = mflags & d[14:8];
    mflags = mflags | ev;
    if (we && sel) mctrl = {d[15:8], 3'b000, d[4:0]};
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd13));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ctrl reset", ctrl_rd, 16'h0003);
    chk("R1 stat reset", stat_rd, 16'h0000);
    @(negedge clk);

    // R2 each source separately
    for (int k = 0; k < 7; k++) cyc(1'b0, 1'b0, '0, 7'(1 << k), '0, '0, "R2");
    cyc(1'b0, 1'b0, '0, '0, '0, '0, "R2 all set");
    // R3 write 1 keeps, write 0 clears selected
    cyc(1'b1, 1'b0, 16'hFFFF, '0, '0, '0, "R3 write ones");
    cyc(1'b1, 1'b0, 16'hAAFF, '0, '0, '0, "R3 partial clear");
    // R4 clear of ERR with concurrent ERR pulse
    cyc(1'b1, 1'b0, 16'h0000, 7'b0100000, '0, '0, "R4 clear vs pulse");
    cyc(1'b0, 1'b0, '0, '0, '0, '0, "R4 survives");
    // R6 highest index only, then rx+tx on same endpoint with higher pending
    cyc(1'b0, 1'b0, '0, '0, 8'h00, 8'h80, "R6 top tx");
    cyc(1'b0, 1'b0, '0, '0, 8'h80, 8'h00, "R6 top rx");
    cyc(1'b0, 1'b0, '0, '0, 8'h24, 8'h84, "R6 rx+tx");
    cyc(1'b0, 1'b0, '0, '0, 8'h20, 8'h04, "R6 tx lower");
    // R5 writes cannot alter the read-only fields
    cyc(1'b1, 1'b0, 16'h0000, '0, 8'h00, 8'h02, "R5 write over ro");
    cyc(1'b0, 1'b0, '0, '0, 8'h00, 8'h02, "R5 after write");
    // R7 control write, R9 status unaffected
    cyc(1'b1, 1'b1, 16'hFFFF, '0, '0, '0, "R7 ctrl all");
    cyc(1'b1, 1'b0, 16'h8000, 7'b0000010, 8'h01, 8'h00, "R9 stat write");
    // R8 mask toggling with SOF pending
    cyc(1'b1, 1'b1, 16'h0200, '0, '0, '0, "R8 only sof");
    cyc(1'b1, 1'b1, 16'hFD1F, '0, '0, '0, "R8 sof masked");
    cyc(1'b0, 1'b0, '0, '0, '0, '0, "R8 masked hold");

    for (int n = 0; n < 3000; n++) begin
      logic we  = ($urandom % 4) == 0;
      logic sel = $urandom % 2;
      logic [15:0] d = 16'($urandom);
      logic [6:0] ev = 7'($urandom & $urandom & $urandom);
      logic [NEP-1:0] rx = NEP'($urandom & $urandom & $urandom);
      logic [NEP-1:0] tx = NEP'($urandom & $urandom & $urandom);
      cyc(we, sel, d, ev, rx, tx, "R2 R3 R4 R5 R6 R7 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule